// File: doc/BRIEF.md
# Per-Line Edge/Level Interrupt Request Latch

This block keeps the pending-request vector for one bank of interrupt lines in a programmable interrupt controller. Every line runs in one of two trigger modes, picked by a trigger-mode register. In level mode the pending bit follows the input. In edge mode the pending bit is set when the input rises, and it stays set until the line is acknowledged. The rising edge is found by comparing the input with a stored copy of its level from the previous sample.

Software writes the trigger-mode register through a parallel write port and reads it back. The written value is ANDed with a fixed writable-bit mask that each instance sets by parameter, so selected lines can never leave edge mode. Each sampled request reports one of two outcomes on registered per-line flags: it was latched as a new request, or it was blocked by the line's mask bit. A masked request still updates the pending vector. Priority resolution, in-service tracking and processor signalling are handled by neighbouring blocks.

Top module: `irq_req_latch`

## Requirements
- R1: A synchronous active-high reset clears the pending vector, the stored input levels, both event-flag vectors and the trigger-mode register to all zeros on the next clock edge. After reset, a line whose input is high is therefore seen as rising.
- R2: A trigger-mode write stores the write data ANDed with WRITABLE_MASK on the clock edge where the write enable is high. The read port returns the stored value from the next cycle on. Bit i set means line i is in level mode; bit i clear means edge mode.
- R3: In level mode, pending bit i is 1 one cycle after input i is sampled high, and 0 one cycle after it is sampled low.
- R4: In edge mode, pending bit i is set one cycle after input i is sampled high when the stored level of line i is low. Holding the input high does not set the bit again.
- R5: In edge mode, a low input leaves the pending bit unchanged and clears the stored level.
- R6: An acknowledge strobe on line i clears pending bit i one cycle later, but only when the line is in edge mode. In level mode the strobe has no effect.
- R7: A sampled request on a line whose mask bit is high raises the masked flag for one cycle and does not raise the new flag. The pending bit is still updated. A request is a level-mode high input or an edge-mode rising edge.
- R8: The new flag of line i rises for one cycle only for an unmasked request whose pending bit was clear before that edge.
- R9: When an edge-mode acknowledge and a rising edge arrive on the same line in the same cycle, the rising edge wins and the pending bit stays 1.
- R10: The stored level is updated in both modes. A line switched from level to edge mode while its input is high sees no edge until the input falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | NUM_LINES | Raw interrupt request lines |
| mask_in | input | NUM_LINES | Per-line mask; 1 blocks event reporting |
| ack_in | input | NUM_LINES | Per-line acknowledge strobe |
| tm_wr_en | input | 1 | Trigger-mode register write enable |
| tm_wr_data | input | NUM_LINES | Trigger-mode write data (1 = level) |
| tm_rd_data | output | NUM_LINES | Trigger-mode register contents |
| pending | output | NUM_LINES | Pending-request vector |
| new_evt | output | NUM_LINES | One-cycle flag: request newly latched |
| masked_evt | output | NUM_LINES | One-cycle flag: request blocked by mask |

## Verification
The bound checker tests these rules on every cycle:
- a level-mode line high in one cycle is pending in the next, and low in one cycle is clear in the next;
- an edge-mode line that is low and not acknowledged keeps its pending bit;
- a new flag never appears on a line that was already pending, and the two event flags never occur together;
- the trigger-mode register never holds a bit outside the writable mask.

Some behaviour depends on the history of a line, so only the bench scenarios can show it:
- an edge stays pending after the input drops, until it is acknowledged;
- a mode switch while the input is held high produces no edge;
- a rising edge wins over an acknowledge in the same cycle;
- a line left high through reset is detected again as a rising edge.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  // Per-line registered state
  typedef struct packed {
    logic pend;
    logic last;
    logic new_f;
    logic mask_f;
  } line_state_t;

  localparam line_state_t LINE_STATE_RESET = '{pend: 1'b0, last: 1'b0, new_f: 1'b0, mask_f: 1'b0};

endpackage

// File: rtl/trig_mode_reg.sv
module trig_mode_reg #(
  parameter int                   NUM_LINES     = 8,
  parameter logic [NUM_LINES-1:0] WRITABLE_MASK = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] mode
);

  logic [NUM_LINES-1:0] mode_q;

  // Bits outside the writable mask are always stored as 0 (edge mode)
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (wr_en) begin
      mode_q <= wr_data & WRITABLE_MASK;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/req_line_cell.sv
module req_line_cell
  import irq_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  trig_mode_e mode,
  input  logic       msk,
  input  logic       ack,
  output logic       pend,
  output logic       new_evt,
  output logic       masked_evt
);

  line_state_t st_q, st_d;
  logic        hit;

  always_comb begin
    // A request is a level-mode high input or an edge-mode rising edge
    hit = req & ((mode == TRIG_LEVEL) | ~st_q.last);
    st_d.last = req;
    if (mode == TRIG_LEVEL) begin
      st_d.pend = req;
    end else if (hit) begin
      st_d.pend = 1'b1;             // a rising edge wins over an acknowledge
    end else if (ack) begin
      st_d.pend = 1'b0;
    end else begin
      st_d.pend = st_q.pend;
    end
    st_d.new_f  = hit & ~msk & ~st_q.pend;
    st_d.mask_f = hit & msk;
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= LINE_STATE_RESET;
    else     st_q <= st_d;
  end

  assign pend       = st_q.pend;
  assign new_evt    = st_q.new_f;
  assign masked_evt = st_q.mask_f;

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int                   NUM_LINES     = 8,
  parameter logic [NUM_LINES-1:0] WRITABLE_MASK = 8'hF8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_in,
  input  logic [NUM_LINES-1:0] mask_in,
  input  logic [NUM_LINES-1:0] ack_in,
  input  logic                 tm_wr_en,
  input  logic [NUM_LINES-1:0] tm_wr_data,
  output logic [NUM_LINES-1:0] tm_rd_data,
  output logic [NUM_LINES-1:0] pending,
  output logic [NUM_LINES-1:0] new_evt,
  output logic [NUM_LINES-1:0] masked_evt
);

  logic [NUM_LINES-1:0] mode_vec;

  trig_mode_reg #(
    .NUM_LINES    (NUM_LINES),
    .WRITABLE_MASK(WRITABLE_MASK)
  ) u_mode (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (tm_wr_en),
    .wr_data(tm_wr_data),
    .mode   (mode_vec)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    req_line_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .req       (req_in[i]),
      .mode      (trig_mode_e'(mode_vec[i])),
      .msk       (mask_in[i]),
      .ack       (ack_in[i]),
      .pend      (pending[i]),
      .new_evt   (new_evt[i]),
      .masked_evt(masked_evt[i])
    );
  end

  assign tm_rd_data = mode_vec;

endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
  parameter int                   NUM_LINES     = 8,
  parameter logic [NUM_LINES-1:0] WRITABLE_MASK = 8'hF8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] req_in,
  input logic [NUM_LINES-1:0] mask_in,
  input logic [NUM_LINES-1:0] ack_in,
  input logic [NUM_LINES-1:0] tm_rd_data,
  input logic [NUM_LINES-1:0] pending,
  input logic [NUM_LINES-1:0] new_evt,
  input logic [NUM_LINES-1:0] masked_evt
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pending == '0 && new_evt == '0 && masked_evt == '0 && tm_rd_data == '0));

  a_r2_mode_within_mask: assert property (@(posedge clk) disable iff (rst)
    (tm_rd_data & ~WRITABLE_MASK) == '0);

  a_r3_level_high_sets: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pending & $past(tm_rd_data & req_in)) == $past(tm_rd_data & req_in)));

  a_r3_level_low_clears: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pending & $past(tm_rd_data & ~req_in)) == '0));

  a_r5_edge_low_holds: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (((pending ^ $past(pending)) & $past(~tm_rd_data & ~req_in & ~ack_in)) == '0));

  a_r7_masked_needs_mask: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((masked_evt & ~$past(mask_in)) == '0));

  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    (new_evt & masked_evt) == '0);

  a_r8_new_only_from_clear: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((new_evt & $past(pending)) == '0 && (new_evt & ~pending) == '0));

endmodule

bind irq_req_latch irq_req_latch_chk #(
  .NUM_LINES    (NUM_LINES),
  .WRITABLE_MASK(WRITABLE_MASK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_in    (req_in),
  .mask_in   (mask_in),
  .ack_in    (ack_in),
  .tm_rd_data(tm_rd_data),
  .pending   (pending),
  .new_evt   (new_evt),
  .masked_evt(masked_evt)
);

// File: tb/irq_req_latch_test.sv
module irq_req_latch_test;

  localparam int          N  = 8;
  localparam logic [N-1:0] WM = 8'hF8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [N-1:0] req_in = '0, mask_in = '0, ack_in = '0, tm_wr_data = '0;
  logic         tm_wr_en = 1'b0;
  logic [N-1:0] tm_rd_data, pending, new_evt, masked_evt;

  irq_req_latch #(.NUM_LINES(N), .WRITABLE_MASK(WM)) uut (
    .clk(clk), .rst(rst), .req_in(req_in), .mask_in(mask_in), .ack_in(ack_in),
    .tm_wr_en(tm_wr_en), .tm_wr_data(tm_wr_data), .tm_rd_data(tm_rd_data),
    .pending(pending), .new_evt(new_evt), .masked_evt(masked_evt)
  );

  int checks = 0;
  int failures = 0;

  // {req, mask, ack, expected pending, expected new, expected masked}
  // Mode is 0xF8: lines 0..2 edge, lines 3..7 level
  localparam logic [47:0] VEC [0:14] = '{
    48'h00_00_00_00_00_00,  // idle
    48'h09_00_00_09_09_00,  // R3 level set, R4 edge set, R8 new
    48'h09_00_00_09_00_00,  // R4 held high no re-set, R8 no new when pending
    48'h00_00_00_01_00_00,  // R3 level clears, R5 edge holds
    48'h00_00_09_00_00_00,  // R6 ack clears edge line
    48'h12_12_00_12_00_12,  // R7 masked, pending still set
    48'h12_12_10_12_00_10,  // R6 level ack ignored, R7 level re-report
    48'h02_00_02_00_00_00,  // R6 edge ack while high, R3 drop
    48'h00_00_00_00_00_00,  // idle
    48'h02_00_00_02_02_00,  // R4 new rising edge
    48'h04_00_02_04_04_00,  // R6 ack line1, R4 rise line2
    48'h00_00_00_04_00_00,  // R5 hold
    48'h04_00_04_04_00_00,  // R9 edge wins over ack
    48'hE0_80_00_E4_60_80,  // R7 and R8 mix on level lines
    48'h00_00_04_00_00_00   // R6 and R3 clear all
  };

  task automatic chk(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [N-1:0] r, input logic [N-1:0] m, input logic [N-1:0] a);
    req_in = r; mask_in = m; ack_in = a;
  endtask

  task automatic write_mode(input logic [N-1:0] d);
    tm_wr_en = 1'b1; tm_wr_data = d;
    step();
    tm_wr_en = 1'b0; tm_wr_data = '0;
  endtask

  initial begin
    repeat (3) step();
    chk("R1", "reset pending", pending, 8'h00);
    chk("R1", "reset new", new_evt, 8'h00);
    chk("R1", "reset masked", masked_evt, 8'h00);
    chk("R1", "reset mode", tm_rd_data, 8'h00);
    rst = 1'b0;
    step();

    write_mode(8'hFF);
    chk("R2", "mode write FF", tm_rd_data, 8'hF8);

    for (int i = 0; i < 15; i++) begin
      drive(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24]);
      step();
      chk("R3/R4/R5/R6/R9", $sformatf("vector %0d pending", i), pending, VEC[i][23:16]);
      chk("R7/R8", $sformatf("vector %0d new", i), new_evt, VEC[i][15:8]);
      chk("R7", $sformatf("vector %0d masked", i), masked_evt, VEC[i][7:0]);
    end
    drive('0, '0, '0);

    write_mode(8'h07);
    chk("R2", "mode write 07 forced to edge", tm_rd_data, 8'h00);

    // R10: switch line 3 from level to edge while its input stays high
    write_mode(8'h08);
    chk("R2", "mode write 08", tm_rd_data, 8'h08);
    drive(8'h08, '0, '0);
    step();
    chk("R3", "level line3 set", pending, 8'h08);
    tm_wr_en = 1'b1; tm_wr_data = 8'h00;
    step();
    tm_wr_en = 1'b0;
    chk("R10", "still pending after switch", pending, 8'h08);
    drive(8'h08, '0, 8'h08);
    step();
    chk("R10", "edge ack with high input clears", pending, 8'h00);
    drive(8'h08, '0, '0);
    step();
    chk("R10", "no edge from held level", pending, 8'h00);
    chk("R10", "no new flag from held level", new_evt, 8'h00);
    drive(8'h00, '0, '0);
    step();
    drive(8'h08, '0, '0);
    step();
    chk("R4", "fresh rise after switch", pending, 8'h08);
    chk("R8", "fresh rise flagged", new_evt, 8'h08);

    // R1: reset in mid-run, then rising detection from cleared levels
    write_mode(8'h30);
    chk("R2", "mode write 30", tm_rd_data, 8'h30);
    drive(8'h31, '0, '0);
    step();
    chk("R3", "mixed lines set", pending, 8'h39);
    rst = 1'b1;
    step();
    chk("R1", "mid-run reset pending", pending, 8'h00);
    chk("R1", "mid-run reset mode", tm_rd_data, 8'h00);
    rst = 1'b0;
    step();
    chk("R1", "held lines seen as rising after reset", pending, 8'h31);
    chk("R1", "held lines flagged new after reset", new_evt, 8'h31);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule